// File: doc/BRIEF.md
# Banked Modular Exponentiation Engine

The engine computes S = M^E mod N on operands of up to `MAX_W` bits (256 by default). Software loads the modulus, message and exponent 32 bits at a time over a small register bus. The bus address holds a two-bit bank code and a three-bit word offset. Two level handshakes drive the work. `pre_start` captures the modulus and the active modulus width and prepares the constant one. `exp_start` runs one exponentiation and leaves the answer in the result bank. The `quick_mode` input chooses between two schedules. The fast schedule skips the multiply on zero exponent bits. The other runs a ladder step of two products for every exponent bit, so that its timing does not depend on the key.

A single bit-serial multiplier does all the arithmetic. It takes one multiplier bit per cycle, doubles the running sum, adds the multiplicand when that bit is set, and then subtracts N up to twice. A sequencer with seven states drives it:

- `S_IDLE`: on a rising `pre_start` it goes to `S_PREP`. Otherwise, on a rising `exp_start` while `pre_done` is high, it goes to `S_REDUCE`.
- `S_PREP`: always returns to `S_IDLE`.
- `S_REDUCE`: reduces M into the range of N. When the product is done it goes to `S_FINISH` if the exponent width is zero, or to `S_MUL_A` otherwise.
- `S_MUL_A`: when done, goes to `S_STEP` in quick mode on a zero bit, or to `S_MUL_B` otherwise.
- `S_MUL_B`: when done, goes to `S_STEP`.
- `S_STEP`: goes to `S_FINISH` after bit 0, or back to `S_MUL_A`.
- `S_FINISH`: writes the result bank and returns to `S_IDLE`.

Top module: `modexp_engine`

## Requirements
- R1: A write happens on a rising clock edge where `reg_sel` and `reg_wr` are both high. `reg_addr[4:3]` selects the bank: 00 modulus, 01 message, 10 exponent, 11 result. `reg_addr[2:0]` selects the word, where word 0 holds bits 31:0, word 1 holds bits 63:32, and so on.
- R2: A read cycle has `reg_sel` high and `reg_wr` low. After the clock edge of a read cycle, `reg_rdata` shows the addressed word, and it holds that value until the next read. After reset it is zero.
- R3: Bus writes to the result bank (code 11) have no effect.
- R4: `pre_done` is low after reset. It goes low at the first edge that samples `pre_start` high after low while the engine is idle, and it goes high again at the following edge.
- R5: `exp_done` is low after reset. A rising `exp_start` is accepted only while idle and with `pre_done` high. `exp_done` goes low at the edge that accepts it. A rising `exp_start` while `pre_done` is low is ignored.
- R6: The result bank receives M^E mod N. Only the low `mod_bits` bits of N and M and the low `exp_bits` bits of E are used. When `exp_bits` is 0 the result is 1 mod N.
- R7: With `quick_mode` low, `exp_done` rises w+3+e(2w+5) edges after the accepting edge, for every exponent value. Here w is the captured modulus width and e the exponent width.
- R8: With `quick_mode` high, `exp_done` rises w+3+Σ(w+3+b·(w+2)) edges after the accepting edge. The sum runs over the e exponent bits, and b is the bit value.
- R9: Bus writes to any operand bank are ignored while an operation is in progress.
- R10: During an exponentiation, reads of the result bank return the previous result.
- R11: The modulus width is captured when `pre_start` is accepted. The exponent width and the mode are captured when `exp_start` is accepted. Later changes on these inputs do not affect the running or prepared work.
- R12: Every modular product, and therefore every result, is less than N (N ≥ 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_start | input | 1 | Level request to prepare the loaded modulus |
| pre_done | output | 1 | Modulus prepared |
| exp_start | input | 1 | Level request to exponentiate |
| exp_done | output | 1 | Result bank holds the finished result |
| mod_bits | input | WW | Active modulus width in bits |
| exp_bits | input | WW | Active exponent width in bits |
| quick_mode | input | 1 | 1: fast variable-time schedule; 0: uniform ladder |
| reg_sel | input | 1 | Bus select |
| reg_wr | input | 1 | Bus write enable |
| reg_addr | input | 5 | {bank, word offset} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The two handshake outputs can be predicted exactly from the widths and the exponent bits.

- `pre_done` is due low one edge after `pre_start` is accepted and high one edge after that.
- `exp_done` is due after the R7 or R8 edge count, which depends on the mode.
- Read data is due one edge after the read request.

The bench computes these counts from the formulas and compares both handshake outputs at every falling edge against the expected level, so an early or late edge is caught in the exact cycle. It writes and reads the bus in the middle of an exponentiation at chosen cycle offsets to check the locking and the stale result reads.

// File: rtl/modexp_pkg.sv
package modexp_pkg;
    localparam int BUS_W = 32;

    localparam logic [1:0] BANK_MOD = 2'b00;
    localparam logic [1:0] BANK_MSG = 2'b01;
    localparam logic [1:0] BANK_EXP = 2'b10;
    localparam logic [1:0] BANK_RES = 2'b11;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREP,
        S_REDUCE,
        S_MUL_A,
        S_MUL_B,
        S_STEP,
        S_FINISH
    } seq_state_t;
endpackage

// File: rtl/mx_operand_bank.sv
module mx_operand_bank
    import modexp_pkg::*;
#(
    parameter int MAX_W = 256,
    localparam int NW = MAX_W / BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic             lock,
    input  logic [4:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    input  logic             res_we,
    input  logic [MAX_W-1:0] res_val,
    output logic [BUS_W-1:0] rdata,
    output logic [MAX_W-1:0] n_o,
    output logic [MAX_W-1:0] m_o,
    output logic [MAX_W-1:0] e_o
);
    logic [1:0]       bsel;
    logic [2:0]       off;
    logic             in_range;
    logic [MAX_W-1:0] vec [4];
    logic [BUS_W-1:0] rd_word;

    assign bsel     = addr[4:3];
    assign off      = addr[2:0];
    assign in_range = (int'(off) < NW);

    for (genvar gi = 0; gi < 4; gi++) begin : g_bank
        logic [MAX_W-1:0] q;
        if (gi == 3) begin : g_res
            // R3: the result bank only takes the sequencer's value
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      q <= '0;
                else if (res_we) q <= res_val;
            end
        end else begin : g_op
            // R1, R9: word write, blocked while busy
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (sel && wr && !lock && in_range && int'(bsel) == gi) begin
                    q[int'(off)*BUS_W +: BUS_W] <= wdata;
                end
            end
        end
        assign vec[gi] = q;
    end

    always_comb begin
        rd_word = '0;
        if (in_range) rd_word = vec[bsel][int'(off)*BUS_W +: BUS_W];
    end

    // R2: registered read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           rdata <= '0;
        else if (sel && !wr)  rdata <= rd_word;
    end

    assign n_o = vec[0];
    assign m_o = vec[1];
    assign e_o = vec[2];
endmodule

// File: rtl/mx_serial_mul.sv
module mx_serial_mul #(
    parameter int MAX_W = 256,
    parameter int WW    = $clog2(MAX_W) + 1,
    localparam int IDXW = $clog2(MAX_W),
    localparam int AW   = MAX_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WW-1:0]    width,
    input  logic [MAX_W-1:0] a,
    input  logic [MAX_W-1:0] b,
    input  logic [MAX_W-1:0] n,
    output logic             done,
    output logic [MAX_W-1:0] p
);
    logic [AW-1:0] acc_q, sum, n1, n2, nxt;
    logic [WW-1:0] cnt_q, cm1;
    logic          busy_q, bit_b;

    assign cm1   = cnt_q - 1'b1;
    assign bit_b = b[cm1[IDXW-1:0]];
    assign n1    = {2'b00, n};
    assign n2    = {1'b0, n, 1'b0};

    always_comb begin
        sum = {acc_q[AW-2:0], 1'b0} + (bit_b ? {2'b00, a} : {AW{1'b0}});
        if (sum >= n2)      nxt = sum - n2;
        else if (sum >= n1) nxt = sum - n1;
        else                nxt = sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                acc_q  <= '0;
                cnt_q  <= width;
                busy_q <= (width != '0);
                done   <= (width == '0);
            end else if (busy_q) begin
                acc_q <= nxt;
                cnt_q <= cm1;
                if (cnt_q == 1) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign p = acc_q[MAX_W-1:0];

    a_r12_product_below_n: assert property (@(posedge clk) disable iff (!rst_n)
        (done && n != '0) |-> (p < n))
        else $error("R12: product not reduced below modulus");
endmodule

// File: rtl/modexp_engine.sv
module modexp_engine
    import modexp_pkg::*;
#(
    parameter int MAX_W = 256,
    localparam int WW   = $clog2(MAX_W) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pre_start,
    output logic          pre_done,
    input  logic          exp_start,
    output logic          exp_done,
    input  logic [WW-1:0] mod_bits,
    input  logic [WW-1:0] exp_bits,
    input  logic          quick_mode,
    input  logic          reg_sel,
    input  logic          reg_wr,
    input  logic [4:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata
);
    localparam int IDXW = $clog2(MAX_W);

    seq_state_t       state_q, state_d;
    logic             pre_q, exp_q, go_q, ready_q, valid_q, quick_q;
    logic             pre_rise, exp_rise, enter_mul, busy, cur_bit, mul_done;
    logic [WW-1:0]    mw_q, ew_q, bit_q;
    logic [MAX_W-1:0] n_q, unit_q, mred_q, r0_q, r1_q, tmp_q;
    logic [MAX_W-1:0] bank_n, bank_m, bank_e, mul_a, mul_b, mul_p;

    function automatic logic [MAX_W-1:0] low_mask(input logic [WW-1:0] w);
        logic [MAX_W-1:0] m;
        for (int i = 0; i < MAX_W; i++) m[i] = (i < int'(w));
        return m;
    endfunction

    assign pre_rise = pre_start & ~pre_q;
    assign exp_rise = exp_start & ~exp_q;
    assign busy     = (state_q != S_IDLE);
    assign cur_bit  = bank_e[bit_q[IDXW-1:0]];

    mx_operand_bank #(.MAX_W(MAX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr), .lock(busy),
        .addr(reg_addr), .wdata(reg_wdata), .res_we(state_q == S_FINISH),
        .res_val(r0_q), .rdata(reg_rdata), .n_o(bank_n), .m_o(bank_m), .e_o(bank_e)
    );

    mx_serial_mul #(.MAX_W(MAX_W), .WW(WW)) u_mul (
        .clk(clk), .rst_n(rst_n), .start(go_q), .width(mw_q),
        .a(mul_a), .b(mul_b), .n(n_q), .done(mul_done), .p(mul_p)
    );

    // operand selection per state
    always_comb begin
        mul_a = r0_q;
        mul_b = r0_q;
        unique case (state_q)
            S_REDUCE: begin mul_a = unit_q; mul_b = bank_m; end
            S_MUL_A:  begin mul_a = r0_q;   mul_b = quick_q ? r0_q : r1_q; end
            S_MUL_B:  begin
                if (quick_q) begin mul_a = r0_q; mul_b = mred_q; end
                else begin
                    mul_a = cur_bit ? r1_q : r0_q;
                    mul_b = cur_bit ? r1_q : r0_q;
                end
            end
            default: ;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (pre_rise) state_d = S_PREP;
                      else if (exp_rise && ready_q) state_d = S_REDUCE;
            S_PREP:   state_d = S_IDLE;
            S_REDUCE: if (mul_done) state_d = (ew_q == '0) ? S_FINISH : S_MUL_A;
            S_MUL_A:  if (mul_done) state_d = (quick_q && !cur_bit) ? S_STEP : S_MUL_B;
            S_MUL_B:  if (mul_done) state_d = S_STEP;
            S_STEP:   state_d = (bit_q == '0) ? S_FINISH : S_MUL_A;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    assign enter_mul = (state_d == S_REDUCE || state_d == S_MUL_A || state_d == S_MUL_B)
                       && (state_d != state_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= 1'b0; exp_q <= 1'b0; go_q <= 1'b0;
            ready_q <= 1'b0; valid_q <= 1'b0; quick_q <= 1'b0;
            mw_q <= '0; ew_q <= '0; bit_q <= '0;
            n_q <= '0; unit_q <= '0; mred_q <= '0;
            r0_q <= '0; r1_q <= '0; tmp_q <= '0;
        end else begin
            pre_q <= pre_start;
            exp_q <= exp_start;
            go_q  <= enter_mul;
            unique case (state_q)
                S_IDLE: begin
                    if (pre_rise) begin
                        n_q     <= bank_n & low_mask(mod_bits);
                        mw_q    <= mod_bits;
                        ready_q <= 1'b0;
                    end else if (exp_rise && ready_q) begin
                        ew_q    <= exp_bits;
                        quick_q <= quick_mode;
                        valid_q <= 1'b0;
                    end
                end
                S_PREP: begin
                    unit_q  <= (n_q > 1) ? {{(MAX_W-1){1'b0}}, 1'b1} : '0;
                    ready_q <= 1'b1;
                end
                S_REDUCE: if (mul_done) begin
                    mred_q <= mul_p;
                    r0_q   <= unit_q;
                    r1_q   <= mul_p;
                    bit_q  <= ew_q - 1'b1;
                end
                S_MUL_A: if (mul_done) begin
                    if (quick_q) r0_q  <= mul_p;
                    else         tmp_q <= mul_p;
                end
                S_MUL_B: if (mul_done) begin
                    if (quick_q) r0_q <= mul_p;
                    else if (cur_bit) begin r1_q <= mul_p; r0_q <= tmp_q; end
                    else              begin r0_q <= mul_p; r1_q <= tmp_q; end
                end
                S_STEP:   if (bit_q != '0) bit_q <= bit_q - 1'b1;
                S_FINISH: valid_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign pre_done = ready_q;
    assign exp_done = valid_q;

    a_r4_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && pre_start && !pre_q) |=> !pre_done)
        else $error("R4: ready did not drop");
    a_r4_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PREP) |=> pre_done)
        else $error("R4: ready did not return");
    a_r5_valid_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && state_q != S_PREP) |-> !exp_done)
        else $error("R5: valid high during exponentiation");
    a_r9_banks_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(bank_n) && $stable(bank_m) && $stable(bank_e)))
        else $error("R9: operand bank changed while busy");
    a_r7_ladder_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MUL_A && !quick_q && mul_done) |=> (state_q == S_MUL_B))
        else $error("R7: ladder step skipped a product");
endmodule

// File: tb/modexp_engine_bench.sv
`timescale 1ns / 1ps
module modexp_engine_bench;
    localparam int MAX_W = 256;
    localparam int WW    = $clog2(MAX_W) + 1;
    localparam logic [1:0] B_MOD = 2'b00, B_MSG = 2'b01, B_EXP = 2'b10, B_RES = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pre_start = 1'b0, exp_start = 1'b0, quick_mode = 1'b0;
    logic [WW-1:0] mod_bits = '0, exp_bits = '0;
    logic reg_sel = 1'b0, reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic pre_done, exp_done;
    logic [31:0] reg_rdata;

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    logic [255:0] cur_n, cur_m, cur_e, last_res;
    int cur_mw;

    always #2 clk = ~clk;

    modexp_engine #(.MAX_W(MAX_W)) u_modexp_engine (
        .clk(clk), .rst_n(rst_n), .pre_start(pre_start), .pre_done(pre_done),
        .exp_start(exp_start), .exp_done(exp_done), .mod_bits(mod_bits),
        .exp_bits(exp_bits), .quick_mode(quick_mode), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string req,
                         input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [511:0] wmask(input int w);
        return (512'd1 << w) - 512'd1;
    endfunction

    function automatic logic [255:0] ref_pow(input logic [255:0] m, input logic [255:0] e,
                                             input logic [255:0] n, input int mw, input int ew);
        logic [511:0] nn, r, b;
        nn = {256'd0, n} & wmask(mw);
        b  = ({256'd0, m} & wmask(mw)) % nn;
        r  = 512'd1 % nn;
        for (int i = ew - 1; i >= 0; i--) begin
            r = (r * r) % nn;
            if (e[i]) r = (r * b) % nn;
        end
        return r[255:0];
    endfunction

    function automatic int latency(input bit quick, input int w, input int ew,
                                   input logic [255:0] e);
        int d = w + 3;
        for (int i = 0; i < ew; i++) begin
            if (quick) d += w + 3 + (e[i] ? w + 2 : 0);
            else       d += 2 * w + 5;
        end
        return d;
    endfunction

    task automatic bus_write(input logic [1:0] bank, input int off, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = {bank, 3'(off)}; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] bank, input int off, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = {bank, 3'(off)};
        @(negedge clk);
        d = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic write_op(input logic [1:0] bank, input logic [255:0] v);
        for (int w = 0; w < 8; w++) bus_write(bank, w, v[w*32 +: 32]);
    endtask

    task automatic read_op(input logic [1:0] bank, output logic [255:0] v);
        logic [31:0] d;
        for (int w = 0; w < 8; w++) begin
            bus_read(bank, w, d);
            v[w*32 +: 32] = d;
        end
    endtask

    task automatic do_init(input int mw);
        mod_bits = WW'(mw);
        cur_mw = mw;
        @(negedge clk);
        pre_start = 1'b1;
        for (int n = 1; n <= 3; n++) begin
            @(negedge clk);
            check(pre_done == (n >= 2), "R4 pre_done timing", 256'(pre_done), 256'(n >= 2));
        end
        pre_start = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_exp(input bit quick, input int ew, input bit poke);
        int d;
        logic [255:0] got, want;
        d = latency(quick, cur_mw, ew, cur_e);
        want = ref_pow(cur_m, cur_e, cur_n, cur_mw, ew);
        exp_bits = WW'(ew);
        quick_mode = quick;
        @(negedge clk);
        exp_start = 1'b1;
        for (int n = 1; n <= d + 2; n++) begin
            @(negedge clk);
            if (n == 2) begin
                // R11: input changes after acceptance have no effect
                quick_mode = ~quick;
                exp_bits = WW'(ew + 1);
            end
            if (poke) begin
                if (n == 3) begin
                    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = {B_MSG, 3'd0};
                    reg_wdata = 32'hDEAD_BEEF;
                end else if (n == 4) begin
                    reg_wr = 1'b0; reg_addr = {B_RES, 3'd0};
                end else if (n == 5) begin
                    reg_sel = 1'b0;
                    check(reg_rdata == last_res[31:0], "R10 stale result read",
                          256'(reg_rdata), 256'(last_res[31:0]));
                end
            end
            if (quick)
                check(exp_done == (n >= d + 1), "R8 quick-mode done timing",
                      256'(exp_done), 256'(n >= d + 1));
            else
                check(exp_done == (n >= d + 1), "R7 ladder done timing",
                      256'(exp_done), 256'(n >= d + 1));
        end
        exp_start = 1'b0;
        read_op(B_RES, got);
        check(got == want, "R6 result value", got, want);
        check(got < (cur_n & wmask(cur_mw)[255:0]), "R12 result below modulus",
              got, cur_n & wmask(cur_mw)[255:0]);
        last_res = want;
        if (poke) begin
            logic [31:0] w0;
            bus_read(B_MSG, 0, w0);
            check(w0 == cur_m[31:0], "R9 write during busy ignored", 256'(w0), 256'(cur_m[31:0]));
        end
    endtask

    task automatic load(input logic [255:0] n, input logic [255:0] m, input logic [255:0] e);
        cur_n = n; cur_m = m; cur_e = e;
        write_op(B_MOD, n);
        write_op(B_MSG, m);
        write_op(B_EXP, e);
    endtask

    initial begin
        logic [255:0] rb;
        last_res = '0;
        cur_mw = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pre_done == 1'b0, "R4 reset pre_done", 256'(pre_done), 256'd0);
        check(exp_done == 1'b0, "R5 reset exp_done", 256'(exp_done), 256'd0);
        check(reg_rdata == 32'd0, "R2 reset read data", 256'(reg_rdata), 256'd0);

        // R5: start ignored before the modulus is prepared
        exp_start = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(exp_done == 1'b0 && pre_done == 1'b0, "R5 start ignored when not ready",
                  256'({pre_done, exp_done}), 256'd0);
        end
        exp_start = 1'b0;

        // 32-bit modulus; upper bits of N and M must be masked (R6)
        load(256'h0000_ABCD_0123_F1E2_D3C5, 256'h9876_5432_1234_5678_9ABC_DEF0,
             256'h8000_0011);
        read_op(B_MSG, rb);
        check(rb == cur_m, "R1 R2 message bank readback", rb, cur_m);
        do_init(32);
        run_exp(1'b1, 32, 1'b0);
        run_exp(1'b0, 32, 1'b0);
        cur_e = 256'hFFFF_FFFF;
        write_op(B_EXP, cur_e);
        run_exp(1'b0, 32, 1'b0);

        // R11: modulus width input changes after preparation
        mod_bits = WW'(64);
        run_exp(1'b1, 32, 1'b0);

        // R3: result bank not writable
        bus_write(B_RES, 0, 32'h5555_AAAA);
        bus_read(B_RES, 0, rb[31:0]);
        check(rb[31:0] == last_res[31:0], "R3 result bank write ignored",
              256'(rb[31:0]), 256'(last_res[31:0]));

        // 64-bit even modulus, message above N, bus pokes while busy
        load(256'hC3A5_1F00_7E24_9B18, 256'hFFFF_FFFF_FFFF_FFF1, 256'h0123_4567_89AB_CDEF);
        do_init(64);
        run_exp(1'b0, 64, 1'b1);
        run_exp(1'b1, 0, 1'b0);

        // 128-bit
        load(256'hE9F1_0A3B_55C7_2D8E_1B64_F0A9_3C2E_7D51,
             256'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 256'hA5C3F);
        do_init(128);
        run_exp(1'b1, 20, 1'b1);

        // full 256-bit width
        load(256'hF123_4567_89AB_CDEF_0246_8ACE_1357_9BDF_A5A5_5A5A_C3C3_3C3C_DEAD_BEEF_1234_5677,
             256'h7FFF_0000_1111_2222_3333_4444_5555_6666_7777_8888_9999_AAAA_BBBB_CCCC_DDDD_EEEE,
             256'hB5);
        do_init(256);
        run_exp(1'b0, 8, 1'b0);
        run_exp(1'b1, 8, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule